// File: doc/BRIEF.md
# LVDS ADC Deskew Training Controller

This block finds a good capture delay for a serial LVDS ADC link. It sweeps an input delay line through all 32 tap settings. At each tap it issues a one-cycle load strobe and waits a fixed number of settle cycles. It then takes two readings: the deserialized bit-clock sample, and a run of recovered data words. The ADC is held in its deskew test mode, so every correct 12-bit word is 0x555.

The clock sample reads zero on one side of the clock edge and nonzero on the other. A change in that zero/nonzero flag between two neighbouring taps marks a window boundary. The block picks the tap midway between the boundaries. It commits that tap only if the data words there matched the test word. If the search fails, it raises a fail flag and reloads the last tap it committed.

A retrain pulse starts the sweep again, so the setting can follow drift with temperature while the link runs. The delay line and the deserializer sit outside the block.

Top module: `lvds_deskew_trainer`

## Requirements
- R1: While reset is low, `tap` is 0 and `tap_load`, `locked` and `fail` are low. The first rising edge after reset is released starts a sweep.
- R2: A sweep loads taps 0 to 31 in increasing order. Each tap is held for 1 + SETTLE + MATCH_N cycles, and `tap_load` is high only in the first of those cycles. Inputs are sampled only in the last MATCH_N cycles.
- R3: A tap's clock flag is whether `clk_sample` equals zero in its first sampling cycle. A transition is a tap t ≥ 1 whose flag differs from that of tap t−1. With the first two transitions at a and b, the candidate is floor((a+b)/2). With a single transition, b is taken as 31.
- R4: A tap passes the data check only if all MATCH_N consecutive sampled words equal 0x555. One mismatching word makes the tap fail.
- R5: If the candidate passes the data check, the cycle after the last tap's samples loads the candidate with a `tap_load` pulse and raises `locked`.
- R6: If there is no transition, or the candidate fails the data check, that same cycle raises `fail` and reloads the last committed tap with a `tap_load` pulse. Before any commit, the last committed tap is 0. `locked` stays low.
- R7: A `retrain` pulse while idle clears `locked` and `fail` on the next edge. The sweep at tap 0 then begins on the following edge.
- R8: A `retrain` pulse that arrives during a sweep is ignored. The sweep and its result are unchanged.
- R9: `tap` changes only in a cycle where `tap_load` is high. `tap_load` is never high for two cycles in a row.
- R10: `locked` and `fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retrain | input | 1 | Request to rerun the sweep |
| clk_sample | input | CS_W | Deserialized bit-clock sample |
| data_word | input | WORD_W | Recovered ADC word |
| tap | output | TAP_W | Delay tap setting |
| tap_load | output | 1 | One-cycle strobe to load `tap` into the delay line |
| locked | output | 1 | A tap has been committed |
| fail | output | 1 | The last search found no usable tap |

## Verification
The embedded assertions check three rules on every cycle: the tap moves only under a load strobe, the strobe never lasts two cycles, and the locked and fail flags stay mutually exclusive. They also check that each flag rises only together with a load. Only the bench's scenarios can show the rest, because these depend on the input pattern the sweep sees:
- the order and dwell of the sweep;
- the midpoint arithmetic, including the single-transition case;
- rejection of a tap whose words only sometimes match;
- the hold-previous-tap behaviour on failure;
- the dropping of a retrain request that arrives mid-sweep.

// File: rtl/lvds_deskew_trainer.sv
module lvds_deskew_trainer #(
  parameter int TAP_W = 5,
  parameter int CS_W = 6,
  parameter int WORD_W = 12,
  parameter logic [WORD_W-1:0] PATTERN = 'h555,
  parameter int SETTLE = 4,
  parameter int MATCH_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retrain,
  input  logic [CS_W-1:0]   clk_sample,
  input  logic [WORD_W-1:0] data_word,
  output logic [TAP_W-1:0]  tap,
  output logic              tap_load,
  output logic              locked,
  output logic              fail
);
  localparam int NTAP = 1 << TAP_W;
  localparam int CNT_W = $clog2(SETTLE + MATCH_N + 1);
  localparam logic [TAP_W-1:0] TAP_MAX = TAP_W'(NTAP - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SETTLE, S_SAMPLE, S_DECIDE} st_t;

  st_t              st;
  logic [TAP_W-1:0] cur, edge_a, edge_b, commit_tap;
  logic [CNT_W-1:0] cnt;
  logic             run_ok, z_first, prev_z, have_a, have_b;
  logic [NTAP-1:0]  valid;

  wire              z_now    = (cnt == '0) ? (clk_sample == '0) : z_first;
  wire              ok_now   = ((cnt == '0) || run_ok) && (data_word == PATTERN);
  wire              last_smp = cnt == CNT_W'(MATCH_N - 1);
  wire [TAP_W:0]    span     = {1'b0, edge_a} + {1'b0, (have_b ? edge_b : TAP_MAX)};
  wire [TAP_W-1:0]  centre   = span[TAP_W:1];
  wire              good     = have_a && valid[centre];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_LOAD;
      cur <= '0;
      cnt <= '0;
      tap <= '0;
      tap_load <= 1'b0;
      locked <= 1'b0;
      fail <= 1'b0;
      commit_tap <= '0;
      run_ok <= 1'b0;
      z_first <= 1'b0;
      prev_z <= 1'b0;
      have_a <= 1'b0;
      have_b <= 1'b0;
      edge_a <= '0;
      edge_b <= '0;
      valid <= '0;
    end else begin
      tap_load <= 1'b0;
      case (st)
        S_IDLE: if (retrain) begin
          cur <= '0;
          have_a <= 1'b0;
          have_b <= 1'b0;
          locked <= 1'b0;
          fail <= 1'b0;
          st <= S_LOAD;
        end
        S_LOAD: begin
          tap <= cur;
          tap_load <= 1'b1;
          cnt <= '0;
          st <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt == CNT_W'(SETTLE - 1)) begin
            cnt <= '0;
            st <= S_SAMPLE;
          end else cnt <= cnt + 1'b1;
        end
        S_SAMPLE: begin
          z_first <= z_now;
          run_ok <= ok_now;
          cnt <= cnt + 1'b1;
          if (last_smp) begin
            valid[cur] <= ok_now;
            prev_z <= z_now;
            if (cur != '0 && z_now != prev_z) begin
              if (!have_a) begin
                have_a <= 1'b1;
                edge_a <= cur;
              end else if (!have_b) begin
                have_b <= 1'b1;
                edge_b <= cur;
              end
            end
            if (cur == TAP_MAX) st <= S_DECIDE;
            else begin
              cur <= cur + 1'b1;
              st <= S_LOAD;
            end
          end
        end
        S_DECIDE: begin
          tap_load <= 1'b1;
          if (good) begin
            tap <= centre;
            commit_tap <= centre;
            locked <= 1'b1;
          end else begin
            tap <= commit_tap;
            fail <= 1'b1;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  tap_moves_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap) |-> tap_load);
  // R9
  load_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_load |=> !tap_load);
  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && fail));
  // R5
  lock_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> tap_load);
  // R6
  fail_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (tap_load && !locked));
endmodule

// File: tb/lvds_deskew_trainer_tb.sv
module lvds_deskew_trainer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 4;
  localparam int MATCH_N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retrain = 1'b0;
  logic [5:0] clk_sample;
  logic [11:0] data_word;
  logic [4:0] tap;
  logic tap_load, locked, fail;

  bit clk_nz [0:31];
  bit data_ok [0:31];
  logic [5:0] glitch_tap = 6'h3F;
  logic ph = 1'b0;

  int vectors = 0, miscompares = 0;
  logic [7:0] q [$];
  logic [4:0] exp_tap = '0;
  logic exp_load = 0, exp_locked = 0, exp_fail = 0;
  int commit = 0;
  string req = "R1 R2";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ph <= ~ph;

  assign clk_sample = clk_nz[tap] ? 6'b000111 : 6'b0;
  assign data_word = (data_ok[tap] && !({1'b0, tap} == glitch_tap && ph)) ? 12'h555 : 12'h554;

  lvds_deskew_trainer #(.SETTLE(SETTLE), .MATCH_N(MATCH_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .retrain(retrain), .clk_sample(clk_sample),
    .data_word(data_word), .tap(tap), .tap_load(tap_load), .locked(locked), .fail(fail));

  function automatic void set_env(int clo, int chi, int dlo, int dhi, int g);
    for (int t = 0; t < 32; t++) begin
      clk_nz[t] = (t >= clo && t <= chi);
      data_ok[t] = (t >= dlo && t <= dhi);
    end
    glitch_tap = (g < 0) ? 6'h3F : 6'(g);
  endfunction

  // R2 R3 R4 R5 R6: expected output sequence of one full sweep
  function automatic void build_sweep();
    int a = -1, b = -1, c;
    bit ok;
    for (int t = 0; t < 32; t++) begin
      q.push_back({5'(t), 3'b100});
      for (int k = 0; k < SETTLE + MATCH_N; k++) q.push_back({5'(t), 3'b000});
    end
    for (int t = 1; t < 32; t++)
      if (clk_nz[t] != clk_nz[t-1]) begin
        if (a < 0) a = t; else if (b < 0) b = t;
      end
    ok = 0;
    c = 0;
    if (a >= 0) begin
      c = (a + ((b < 0) ? 31 : b)) / 2;
      ok = data_ok[c] && (c != int'(glitch_tap));
    end
    if (ok) begin
      q.push_back({5'(c), 3'b110});
      commit = c;
    end else q.push_back({5'(commit), 3'b101});
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      exp_tap = '0; exp_load = 0; exp_locked = 0; exp_fail = 0;
    end else if (q.size() != 0) begin
      {exp_tap, exp_load, exp_locked, exp_fail} = q.pop_front();
    end else exp_load = 0;
    vectors++;
    if (tap !== exp_tap || tap_load !== exp_load || locked !== exp_locked || fail !== exp_fail) begin
      miscompares++;
      $display("FAIL %s t=%0t tap=%0d/%0d load=%0b/%0b locked=%0b/%0b fail=%0b/%0b",
               req, $time, tap, exp_tap, tap_load, exp_load, locked, exp_locked, fail, exp_fail);
    end
  end

  task automatic wait_done();
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // R7: accepted request clears flags, then sweeps
  task automatic do_retrain();
    @(negedge clk); #1;
    q.push_back({exp_tap, 3'b000});
    build_sweep();
    retrain = 1'b1;
    @(negedge clk); #1;
    retrain = 1'b0;
  endtask

  initial begin
    // R1: reset state, then R2 R3 R5 R9 R10 on first sweep: edges 1,5 -> tap 3
    set_env(1, 4, 2, 6, -1);
    repeat (3) @(negedge clk);
    #1;
    build_sweep();
    rst_n = 1'b1;
    wait_done();

    // R7 R8: retrain, then a request mid-sweep ignored; edges 10,22 -> 16
    req = "R7 R8 R3 R5";
    set_env(10, 21, 12, 20, -1);
    do_retrain();
    repeat (50) @(negedge clk);
    #1 retrain = 1'b1;
    @(negedge clk); #1 retrain = 1'b0;
    repeat (100) @(negedge clk);
    #1 retrain = 1'b1;
    @(negedge clk); #1 retrain = 1'b0;
    wait_done();

    // R6: no transition at all -> fail, hold 16
    req = "R6 R10 no-transition";
    set_env(40, 40, 0, 31, -1);
    do_retrain();
    wait_done();

    // R6: centre 7 never matches -> fail, hold 16
    req = "R6 R4 bad-centre";
    set_env(4, 9, 0, 0, -1);
    q.delete();
    do_retrain();
    wait_done();

    // R3: single transition at 20 -> (20+31)/2 = 25
    req = "R3 R5 single-edge";
    set_env(20, 31, 22, 28, -1);
    do_retrain();
    wait_done();

    // R4: centre word mismatches on alternate cycles -> rejected, hold 25
    req = "R4 R6 intermittent";
    set_env(1, 4, 2, 6, 3);
    do_retrain();
    wait_done();

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog %s actual=timeout expected=completion", req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule